// File: doc/BRIEF.md
# Quad-Word Byte Link Transmitter

This block moves 128-bit quad-words to a receiver over an 8-bit data bus. The bus travels together with a forwarded link clock, and every edge of that clock carries one byte. The link clock is the port clock divided by two. The data byte therefore changes once per port-clock cycle, and each change lines up with a link-clock edge.

The receiver paces the link with a single ready line. That line is synchronised into the port-clock domain. After ready is seen high, the transmitter waits a programmable number of port-clock cycles and then takes one quad-word from its upstream valid/ready handshake. During a transfer, a low-then-high pulse on the ready line grants the next quad-word, so the next frame can follow with no idle cycle. If no grant pulse is seen, the transmitter parks the link clock low after the last byte and starts the wait again.

Top module: `lqt_link_tx`

## Requirements
- R1: During reset, and while rx_ready stays low after reset, tx_clk is 0, tx_byte is 0 and qw_ready is 0.
- R2: Byte Dk of a frame equals qw_data[8k+7:8k], for k from 0 to 15. The bytes go out in the order D0 to D15, one per port-clock cycle. tx_clk goes high with D0 and toggles with every later byte.
- R3: Whenever no frame is being sent, including the cycle right after D15 of a frame with no grant, tx_clk is 0 and tx_byte is 0.
- R4: Suppose qw_valid is already high and rx_ready rises from an idle link. D0 (tx_clk high) then appears W+4 port-clock edges after the rise, where W is the effective wait.
- R5: The effective wait W is wait_sel, except that any wait_sel value below 6 gives W = 6.
- R6: A low-then-high pulse on the synchronised ready line during a frame is a grant. When a grant has been seen and qw_valid is high at D15, the next frame's D0 comes in the very next cycle.
- R7: Suppose no grant was seen, rx_ready stays high and data is waiting. The next D0 then appears W+3 cycles after D15.
- R8: qw_ready is high only in the cycle where a transfer starts, and never while D0 to D14 are on the bus. The frame is captured in that cycle, so later changes of qw_data have no effect on it. Every accepted frame is sent once, in order.
- R9: If the synchronised ready line falls during the wait, the transmitter returns to idle. A later rise then needs the full W+4 cycles again.
- R10: Suppose a grant was seen but qw_valid is low at D15. The link then holds with tx_clk low and ignores rx_ready. D0 follows one cycle after qw_valid rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| qw_data | input | 128 | Quad-word to send; byte k sits at bits 8k+7:8k |
| qw_valid | input | 1 | Upstream offers a quad-word |
| qw_ready | output | 1 | Quad-word taken this cycle |
| rx_ready | input | 1 | Receiver ready line, asynchronous |
| wait_sel | input | 4 | Programmed startup wait in port-clock cycles |
| tx_byte | output | 8 | Link data byte |
| tx_clk | output | 1 | Forwarded link clock |

## Verification
The embedded properties check several rules on every cycle. The link stays parked (clock low, data zero) outside a transfer, and the link clock toggles in every transmit cycle. A frame is taken only at its boundary and with at least the minimum wait behind it, and the captured frame does not change during its bytes. A drop of ready during the wait sends the block back to idle. Other behaviour shows only in the bench scenarios: the exact start latency for each wait setting, the gap after a frame with and without a grant, the held state when a grant arrives with no data, and the byte-for-byte match of random frames.

// File: rtl/lqt_pkg.sv
package lqt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2,
        ST_HOLD = 2'd3
    } lqt_state_e;

endpackage

// File: rtl/lqt_sync.sv
module lqt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d = q;
        d.pipe = {q.pipe[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.pipe[STAGES-1];

endmodule

// File: rtl/lqt_grant_det.sv
module lqt_grant_det (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic clear_i,
    input  logic rdy_s_i,
    output logic grant_o
);

    typedef struct packed {
        logic low;
        logic grant;
    } gdet_t;

    gdet_t d, q;
    logic  grant_now;

    always_comb begin
        grant_now = q.grant | (arm_i & q.low & rdy_s_i);
        d = q;
        if (clear_i) begin
            d.low   = 1'b0;
            d.grant = 1'b0;
        end else begin
            if (arm_i && !rdy_s_i) begin
                d.low = 1'b1;
            end
            d.grant = grant_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign grant_o = grant_now;

    // A grant may only appear after a low level was recorded on ready
    assert_grant_after_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.grant) |-> $past(q.low));

endmodule

// File: rtl/lqt_byte_sel.sv
module lqt_byte_sel #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 16,
    localparam int IDX_W = $clog2(NBYTES)
) (
    input  logic [BYTE_W*NBYTES-1:0] frame_i,
    input  logic [IDX_W-1:0]         sel_i,
    output logic [BYTE_W-1:0]        byte_o
);

    logic [BYTE_W-1:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = frame_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lanes[sel_i];

endmodule

// File: rtl/lqt_link_tx.sv
module lqt_link_tx
    import lqt_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int NBYTES      = 16,
    parameter int WAIT_W      = 4,
    parameter int MIN_WAIT    = 6,
    parameter int SYNC_STAGES = 2,
    localparam int FRAME_W    = BYTE_W * NBYTES,
    localparam int IDX_W      = $clog2(NBYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] qw_data,
    input  logic               qw_valid,
    output logic               qw_ready,
    input  logic               rx_ready,
    input  logic [WAIT_W-1:0]  wait_sel,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               tx_clk
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NBYTES - 1);
    localparam logic [WAIT_W-1:0] MIN_W    = WAIT_W'(MIN_WAIT);

    typedef struct packed {
        lqt_state_e          state;
        logic [WAIT_W-1:0]   cnt;
        logic [IDX_W-1:0]    idx;
        logic [FRAME_W-1:0]  frame;
        logic [BYTE_W-1:0]   data;
        logic                lclk;
    } tx_t;

    tx_t d, q;

    logic              rdy_s;
    logic              grant_now;
    logic              take;
    logic [WAIT_W-1:0] eff_wait;
    logic [IDX_W-1:0]  nxt_idx;
    logic [BYTE_W-1:0] nxt_byte;

    lqt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rx_ready),
        .sync_o  (rdy_s)
    );

    lqt_grant_det u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (q.state == ST_SEND),
        .clear_i (take),
        .rdy_s_i (rdy_s),
        .grant_o (grant_now)
    );

    assign nxt_idx = q.idx + 1'b1;

    lqt_byte_sel #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_sel (
        .frame_i (q.frame),
        .sel_i   (nxt_idx),
        .byte_o  (nxt_byte)
    );

    assign eff_wait = (wait_sel < MIN_W) ? MIN_W : wait_sel;

    always_comb begin
        d    = q;
        take = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (rdy_s) begin
                    d.state = ST_WAIT;
                    d.cnt   = '0;
                end
            end
            ST_WAIT: begin
                if (!rdy_s) begin
                    d.state = ST_IDLE;
                end else if (q.cnt >= eff_wait) begin
                    take = qw_valid;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SEND: begin
                if (q.idx != LAST_IDX) begin
                    d.idx  = nxt_idx;
                    d.data = nxt_byte;
                    d.lclk = ~q.lclk;
                end else if (grant_now) begin
                    if (qw_valid) begin
                        take = 1'b1;
                    end else begin
                        d.state = ST_HOLD;
                        d.data  = '0;
                        d.lclk  = 1'b0;
                    end
                end else begin
                    d.state = ST_IDLE;
                    d.data  = '0;
                    d.lclk  = 1'b0;
                end
            end
            ST_HOLD: begin
                take = qw_valid;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
        if (take) begin
            d.state = ST_SEND;
            d.idx   = '0;
            d.frame = qw_data;
            d.data  = qw_data[BYTE_W-1:0];
            d.lclk  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign qw_ready = take;
    assign tx_byte  = q.data;
    assign tx_clk   = q.lclk;

    // Link parked outside a transfer
    assert_parked_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_SEND) |-> (!tx_clk && tx_byte == '0));

    // Every transmit cycle moves the link clock
    assert_clock_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SEND && $past(q.state) == ST_SEND) |-> (tx_clk != $past(tx_clk)));

    // A frame leaves the wait only after the minimum count
    assert_min_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (qw_ready && q.state == ST_WAIT) |-> (q.cnt >= MIN_W));

    // Upstream handshake only at a frame boundary
    assert_accept_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        qw_ready |-> (q.state != ST_SEND || q.idx == LAST_IDX));

    // Captured frame stays put while its bytes go out
    assert_frame_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SEND && q.idx != LAST_IDX) |=> $stable(q.frame));

    // Ready lost during the wait drops back to idle
    assert_wait_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && !rdy_s) |=> (q.state == ST_IDLE));

endmodule

// File: tb/lqt_link_tx_test.sv
module lqt_link_tx_test;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] qw_data = '0;
    logic         qw_valid = 1'b0;
    wire          qw_ready;
    logic         rdy_base = 1'b0;
    int           pulse_cnt = 0;
    wire          rx_ready = rdy_base & (pulse_cnt == 0);
    logic [3:0]   wait_sel = '0;
    wire  [7:0]   tx_byte;
    wire          tx_clk;

    always #(CLK_PERIOD/2) clk = ~clk;

    lqt_link_tx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .qw_data  (qw_data),
        .qw_valid (qw_valid),
        .qw_ready (qw_ready),
        .rx_ready (rx_ready),
        .wait_sel (wait_sel),
        .tx_byte  (tx_byte),
        .tx_clk   (tx_clk)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc_cnt = 0;
    int acc_seen = 0;
    int feed_n = 0;
    int pulse_mode = 0;
    int frames_done = 0;
    int bcnt = 0;
    int last_cyc = 0;
    int seq_bad = 0;
    int ready_bad = 0;
    bit chk_gap = 0;
    bit have_prev = 0;
    bit last_granted = 0;
    bit after_end = 0;
    logic prev_clk = 1'b0;
    logic [127:0] got = '0;
    logic [127:0] exp_q [$];

    function automatic int eff_of(input logic [3:0] w);
        return (w < 4'd6) ? 6 : int'(w);
    endfunction

    function automatic logic [127:0] rnd_frame();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // record handshakes
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && qw_valid && qw_ready) begin
            exp_q.push_back(qw_data);
            acc_cnt <= acc_cnt + 1;
        end
    end

    // upstream feeder
    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_cnt != acc_seen) begin
                acc_seen = acc_cnt;
                if (feed_n > 0) begin
                    qw_data = rnd_frame();
                    feed_n--;
                end else begin
                    qw_valid = 1'b0;
                    qw_data  = rnd_frame();
                end
            end else if (!qw_valid && feed_n > 0) begin
                qw_valid = 1'b1;
                qw_data  = rnd_frame();
                feed_n--;
            end
        end
    end

    // link monitor and grant pulse generator
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse_cnt > 0) pulse_cnt--;
            if (tx_clk != prev_clk) begin
                after_end = 0;
                if (bcnt == 0) begin
                    if (chk_gap && have_prev) begin
                        if (last_granted)
                            chk((cyc - last_cyc) == 1, "R6", "gap after granted frame",
                                128'(cyc - last_cyc), 128'd1);
                        else
                            chk((cyc - last_cyc) == eff_of(wait_sel) + 3, "R7",
                                "gap after ungranted frame",
                                128'(cyc - last_cyc), 128'(eff_of(wait_sel) + 3));
                    end
                end else if (cyc != last_cyc + 1) begin
                    seq_bad++;
                end
                got[bcnt*8 +: 8] = tx_byte;
                if (bcnt < 15 && qw_ready) ready_bad++;
                last_cyc = cyc;
                if (bcnt == 3) begin
                    last_granted = 0;
                    if (pulse_mode == 3)
                        last_granted = 1;
                    else if ((pulse_mode == 1 || (pulse_mode == 2 && $urandom_range(1, 0) == 1))
                             && (qw_valid || feed_n > 0))
                        last_granted = 1;
                    if (last_granted) pulse_cnt = 2;
                end
                bcnt++;
                if (bcnt == 16) begin
                    bcnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8", "frame with no accepted data", got, '0);
                    end else begin
                        logic [127:0] e;
                        e = exp_q.pop_front();
                        chk(got == e, "R2", "frame bytes D0..D15", got, e);
                    end
                    chk(seq_bad == 0, "R2", "bytes in consecutive cycles", 128'(seq_bad), 0);
                    chk(ready_bad == 0, "R8", "qw_ready during D0..D14", 128'(ready_bad), 0);
                    seq_bad = 0;
                    ready_bad = 0;
                    have_prev = 1;
                    after_end = 1;
                    frames_done++;
                end
            end else if (after_end) begin
                after_end = 0;
                chk(!tx_clk && tx_byte == 8'd0, "R3", "link parked after D15",
                    {tx_clk, tx_byte}, '0);
            end
            prev_clk = tx_clk;
        end
    end

    task automatic settle_idle();
        rdy_base = 1'b0;
        pulse_mode = 0;
        chk_gap = 0;
        repeat (30) @(negedge clk);
    endtask

    task automatic measure_start(input logic [3:0] w, input string req);
        int n;
        settle_idle();
        wait_sel = w;
        feed_n = 1;
        repeat (3) @(negedge clk);
        rdy_base = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!tx_clk && n < 80);
        chk(n == eff_of(w) + 4, req, $sformatf("start latency wait_sel=%0d", w),
            128'(n), 128'(eff_of(w) + 4));
        repeat (20) @(negedge clk);
    endtask

    task automatic run_stream(input logic [3:0] w, input int mode, input int nfr);
        int s;
        settle_idle();
        wait_sel = w;
        pulse_mode = mode;
        s = frames_done;
        feed_n = nfr;
        rdy_base = 1'b1;
        wait (frames_done >= s + 1);
        chk_gap = 1;
        wait (frames_done >= s + nfr);
        chk_gap = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tx_clk && tx_byte == 8'd0 && !qw_ready, "R1", "outputs in reset",
            {qw_ready, tx_clk, tx_byte}, '0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(!tx_clk && tx_byte == 8'd0 && !qw_ready, "R1", "idle with ready low",
            {qw_ready, tx_clk, tx_byte}, '0);

        measure_start(4'd6,  "R4");
        measure_start(4'd9,  "R4");
        measure_start(4'd15, "R4");
        measure_start(4'd0,  "R5");
        measure_start(4'd3,  "R5");

        // R9: ready drops in the middle of the wait
        begin
            int n;
            settle_idle();
            wait_sel = 4'd8;
            feed_n = 1;
            repeat (3) @(negedge clk);
            rdy_base = 1'b1;
            repeat (3) @(negedge clk);
            rdy_base = 1'b0;
            repeat (2) @(negedge clk);
            rdy_base = 1'b1;
            n = 0;
            do begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end while (!tx_clk && n < 80);
            chk(n == 12, "R9", "full wait after ready drop", 128'(n), 128'd12);
            repeat (20) @(negedge clk);
        end

        run_stream(4'd7, 0, 3);   // R7
        run_stream(4'd6, 1, 4);   // R6

        // R10: grant without data waiting
        begin
            int s;
            int n;
            bit low_ok;
            settle_idle();
            wait_sel = 4'd6;
            pulse_mode = 3;
            s = frames_done;
            feed_n = 1;
            rdy_base = 1'b1;
            wait (frames_done >= s + 1);
            pulse_mode = 0;
            low_ok = 1;
            repeat (12) begin
                @(negedge clk);
                if (tx_clk || qw_ready) low_ok = 0;
            end
            chk(low_ok, "R10", "held parked after grant with no data", 128'(low_ok), 128'd1);
            @(posedge clk);
            feed_n = 1;
            @(negedge clk);
            n = 0;
            do begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end while (!tx_clk && n < 80);
            chk(n == 1, "R10", "start one cycle after valid", 128'(n), 128'd1);
            repeat (25) @(negedge clk);
        end

        // random streams with random grants
        for (int r = 0; r < 3; r++) begin
            run_stream(4'($urandom_range(15, 0)), 2, 8);
        end

        settle_idle();
        chk(exp_q.size() == 0, "R8", "all accepted frames delivered",
            128'(exp_q.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule